// File: doc/BRIEF.md
# Half-to-single float converter

This block widens an IEEE-754 binary16 word into the binary32 word that holds exactly the same value. A producer presents a 16-bit half-precision code together with a valid strobe. One clock later the block presents the 32-bit single-precision code with its own valid strobe. No rounding stage is needed, because every half-precision value, subnormals included, has an exact single-precision encoding.

Each input is sorted into one of five classes: signed zero, subnormal, normal, infinity or NaN. Normal values are rebiased. Subnormal values are renormalised with a staged leading-zero counter, so that their leading one becomes the hidden bit of a normal single. NaNs keep their payload, and the output is always a quiet NaN. The sign bit passes through unchanged in every class.

Top module: `h2s_convert`

## Requirements
- R1: For an input whose exponent field (bits 14:10) is 1 to 30, the output exponent (bits 30:23) is that field plus 112, and the output fraction (bits 22:0) is the input fraction (bits 9:0) shifted left by 13 with zero fill.
- R2: An input with exponent field 0 and fraction 0 gives an output whose bits 30:0 are all zero.
- R3: An input with exponent field 31 and fraction 0 gives output exponent 255 and output fraction 0.
- R4: An input with exponent field 31 and a non-zero fraction gives output exponent 255 and a non-zero output fraction with bit 22 set. Output bits 21:13 equal input bits 8:0, and output bits 12:0 are zero.
- R5: An input with exponent field 0 and a non-zero fraction f gives the normal single whose value is exactly f × 2^-24. In particular, 0x0001 gives 0x33800000 and 0x03FF gives 0x387FC000.
- R6: Output bit 31 equals input bit 15 for every input code.
- R7: When in_valid is high at a rising edge, out_valid is high after that edge and out_single carries that input's result. When in_valid is low at a rising edge, out_valid is low after it.
- R8: While in_valid is low, out_single keeps its previous value whatever is on in_half.
- R9: A synchronous reset (rst high at a rising edge) clears out_valid and out_single to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_half for this cycle |
| in_half | input | 16 | binary16 code: sign 15, exponent 14:10, fraction 9:0 |
| out_valid | output | 1 | out_single holds a fresh result |
| out_single | output | 32 | binary32 code: sign 31, exponent 30:23, fraction 22:0 |

## Verification
The only state is the result register and its valid flag, so a fault in the class decode or in the leading-zero count shows up at out_single exactly one cycle after the input that triggers it. A faulty shift count on a subnormal moves both the exponent and the fraction, and a faulty class decode sends whole exponent ranges to the wrong encoding. The full sweep of all 65536 codes therefore exposes any such fault on the first code that reaches it. A load-enable fault shows up as a changed out_single during an idle cycle, and the hold scenario checks for that.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

  localparam int HALF_W    = 16;
  localparam int HEXP_W    = 5;
  localparam int HFRAC_W   = 10;
  localparam int SINGLE_W  = 32;
  localparam int SEXP_W    = 8;
  localparam int SFRAC_W   = 23;
  localparam int HBIAS     = (1 << (HEXP_W - 1)) - 1;
  localparam int SBIAS     = (1 << (SEXP_W - 1)) - 1;
  localparam int BIAS_DIFF = SBIAS - HBIAS;
  localparam int FRAC_SHL  = SFRAC_W - HFRAC_W;
  localparam int LZC_W     = 1 << $clog2(HFRAC_W + 1);
  localparam int LZC_CW    = $clog2(LZC_W) + 1;
  localparam int LZC_PAD   = LZC_W - HFRAC_W;

  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_norm;
    logic is_sub;
    logic is_zero;
  } h2s_class_t;

  // Normal exponent: move from the half bias to the single bias.
  function automatic logic [SEXP_W-1:0] rebias_exp(input logic [HEXP_W-1:0] e);
    logic [SEXP_W-1:0] ext;
    ext = {{(SEXP_W-HEXP_W){1'b0}}, e};
    return ext + SEXP_W'(BIAS_DIFF);
  endfunction

  // Fraction widening: zero-filled left alignment.
  function automatic logic [SFRAC_W-1:0] widen_frac(input logic [HFRAC_W-1:0] f);
    return {f, {FRAC_SHL{1'b0}}};
  endfunction

  // NaN fraction: payload aligned and quiet bit forced.
  function automatic logic [SFRAC_W-1:0] quiet_frac(input logic [HFRAC_W-1:0] f);
    logic [SFRAC_W-1:0] w;
    w = {f, {FRAC_SHL{1'b0}}};
    w[SFRAC_W-1] = 1'b1;
    return w;
  endfunction

  // Subnormal exponent from the padded leading-zero count.
  function automatic logic [SEXP_W-1:0] sub_exp(input logic [LZC_CW-1:0] lz);
    logic [SEXP_W-1:0] lz_ext;
    lz_ext = {{(SEXP_W-LZC_CW){1'b0}}, lz};
    return SEXP_W'(BIAS_DIFF + LZC_PAD) - lz_ext;
  endfunction

  // Subnormal fraction: drop the leading one, keep the bits below it.
  function automatic logic [SFRAC_W-1:0] sub_frac(input logic [HFRAC_W-1:0] f,
                                                  input logic [LZC_CW-1:0] lz);
    logic [LZC_W-1:0] padded;
    logic [LZC_W-1:0] aligned;
    padded  = {{LZC_PAD{1'b0}}, f};
    aligned = (padded << lz) << 1;
    return {aligned[LZC_W-1 -: HFRAC_W], {FRAC_SHL{1'b0}}};
  endfunction

endpackage

// File: rtl/h2s_classify.sv
module h2s_classify
  import h2s_pkg::*;
(
  input  logic [HALF_W-1:0]  half_i,
  output logic               sign_o,
  output logic [HEXP_W-1:0]  exp_o,
  output logic [HFRAC_W-1:0] frac_o,
  output h2s_class_t         cls_o
);

  logic exp_zero;
  logic exp_full;
  logic frac_zero;

  assign sign_o    = half_i[HALF_W-1];
  assign exp_o     = half_i[HALF_W-2 -: HEXP_W];
  assign frac_o    = half_i[HFRAC_W-1:0];

  assign exp_zero  = (exp_o == '0);
  assign exp_full  = (exp_o == '1);
  assign frac_zero = (frac_o == '0);

  always_comb begin
    cls_o.is_zero = exp_zero & frac_zero;
    cls_o.is_sub  = exp_zero & ~frac_zero;
    cls_o.is_inf  = exp_full & frac_zero;
    cls_o.is_nan  = exp_full & ~frac_zero;
    cls_o.is_norm = ~exp_zero & ~exp_full;
  end

endmodule

// File: rtl/h2s_lzc.sv
module h2s_lzc #(
  parameter int W  = 16,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] count_o
);

  localparam int LVL = $clog2(W);

  logic [LVL:0][W-1:0] stage;
  logic [LVL-1:0]      hit;
  logic                all_zero;

  assign stage[0] = val_i;

  // Each level tests the upper part of what is left, halving the window.
  for (genvar g = 0; g < LVL; g++) begin : g_level
    localparam int SPAN = W >> (g + 1);
    assign hit[LVL-1-g]  = ~|stage[g][W-1 -: SPAN];
    assign stage[g+1]    = hit[LVL-1-g] ? (stage[g] << SPAN) : stage[g];
  end

  assign all_zero = ~stage[LVL][W-1];
  assign count_o  = all_zero ? CW'(W) : {1'b0, hit};

endmodule

// File: rtl/h2s_assemble.sv
module h2s_assemble
  import h2s_pkg::*;
(
  input  logic               sign_i,
  input  logic [HEXP_W-1:0]  exp_i,
  input  logic [HFRAC_W-1:0] frac_i,
  input  h2s_class_t         cls_i,
  input  logic [LZC_CW-1:0]  lz_i,
  output logic [SINGLE_W-1:0] word_o
);

  logic [SEXP_W-1:0]  exp_w;
  logic [SFRAC_W-1:0] frac_w;

  always_comb begin
    exp_w  = '0;
    frac_w = '0;
    if (cls_i.is_norm) begin
      exp_w  = rebias_exp(exp_i);
      frac_w = widen_frac(frac_i);
    end else if (cls_i.is_sub) begin
      exp_w  = sub_exp(lz_i);
      frac_w = sub_frac(frac_i, lz_i);
    end else if (cls_i.is_inf) begin
      exp_w  = '1;
    end else if (cls_i.is_nan) begin
      exp_w  = '1;
      frac_w = quiet_frac(frac_i);
    end
  end

  assign word_o = {sign_i, exp_w, frac_w};

endmodule

// File: rtl/h2s_convert.sv
module h2s_convert
  import h2s_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [HALF_W-1:0]   in_half,
  output logic                out_valid,
  output logic [SINGLE_W-1:0] out_single
);

  logic                sign_w;
  logic [HEXP_W-1:0]   exp_w;
  logic [HFRAC_W-1:0]  frac_w;
  h2s_class_t          cls;
  logic [4:0]          cls_flags;
  logic [LZC_CW-1:0]   lz_count;
  logic [SINGLE_W-1:0] comb_result;

  h2s_classify u_classify (
    .half_i (in_half),
    .sign_o (sign_w),
    .exp_o  (exp_w),
    .frac_o (frac_w),
    .cls_o  (cls)
  );

  assign cls_flags = cls;

  h2s_lzc #(.W(LZC_W), .CW(LZC_CW)) u_lzc (
    .val_i   ({{LZC_PAD{1'b0}}, frac_w}),
    .count_o (lz_count)
  );

  h2s_assemble u_assemble (
    .sign_i (sign_w),
    .exp_i  (exp_w),
    .frac_i (frac_w),
    .cls_i  (cls),
    .lz_i   (lz_count),
    .word_o (comb_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_single <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_single <= comb_result;
    end
  end

endmodule

// File: rtl/h2s_convert_chk.sv
module h2s_convert_chk
  import h2s_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [HALF_W-1:0]   in_half,
  input logic                out_valid,
  input logic [SINGLE_W-1:0] out_single,
  input logic [4:0]          cls_flags,
  input logic [LZC_CW-1:0]   lz_count
);

  // Every code falls into exactly one class (covers the R1..R5 split).
  p_one_class_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(cls_flags) == 1);

  p_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[HALF_W-2:0] == '0) |=> (out_single[SINGLE_W-2:0] == '0));

  p_nan_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_half[HALF_W-2 -: HEXP_W] == '1 && in_half[HFRAC_W-1:0] != '0)
    |=> (out_single[SINGLE_W-2 -: SEXP_W] == '1 && out_single[SFRAC_W-1]));

  // A subnormal always has its leading one inside the fraction window.
  p_sub_count_r5: assert property (@(posedge clk) disable iff (rst)
    (in_half[HALF_W-2 -: HEXP_W] == '0 && in_half[HFRAC_W-1:0] != '0)
    |-> (lz_count >= LZC_CW'(LZC_PAD) && lz_count < LZC_CW'(LZC_W)));

  p_sign_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_single[SINGLE_W-1] == $past(in_half[HALF_W-1])));

  p_valid_on_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_valid_off_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_single));

  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_single == '0));

endmodule

bind h2s_convert h2s_convert_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_half    (in_half),
  .out_valid  (out_valid),
  .out_single (out_single),
  .cls_flags  (cls_flags),
  .lz_count   (lz_count)
);

// File: tb/h2s_convert_test.sv
module h2s_convert_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic [31:0] out_single;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  h2s_convert uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_half    (in_half),
    .out_valid  (out_valid),
    .out_single (out_single)
  );

  // Independent model: value-based reconstruction of the single code.
  function automatic logic [31:0] model(input logic [15:0] h);
    logic [4:0]  e;
    logic [9:0]  f;
    logic [31:0] m;
    int          top;
    e = h[14:10];
    f = h[9:0];
    if (e == 5'd0 && f == 10'd0) return {h[15], 31'd0};
    if (e == 5'd31 && f == 10'd0) return {h[15], 8'hFF, 23'd0};
    if (e == 5'd31) return {h[15], 8'hFF, 1'b1, f[8:0], 13'd0};
    if (e == 5'd0) begin
      top = 0;
      for (int k = 0; k < 10; k++) if (f[k]) top = k;
      m = ({22'd0, f} << (23 - top)) & 32'h007F_FFFF;
      return {h[15], 8'(top + 103), m[22:0]};
    end
    return {h[15], 8'(32'(e) + 112), f, 13'd0};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Present one code; called just after a falling edge, returns after the next one.
  task automatic apply(input logic [15:0] h);
    in_half  = h;
    in_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R9 out_single in reset", out_single, 32'd0);
  endtask

  task automatic t_normals;
    apply(16'h3C00); check("R1 one", out_single, 32'h3F80_0000);
    check("R7 valid", {31'd0, out_valid}, 32'd1);
    apply(16'h0400); check("R1 min normal", out_single, 32'h3880_0000);
    apply(16'h7BFF); check("R1 max normal", out_single, 32'h477F_E000);
    apply(16'hC155); check("R6 negative normal", out_single, 32'hC02A_A000);
  endtask

  task automatic t_zeros_infs;
    apply(16'h0000); check("R2 +0", out_single, 32'h0000_0000);
    apply(16'h8000); check("R2 R6 -0", out_single, 32'h8000_0000);
    apply(16'h7C00); check("R3 +inf", out_single, 32'h7F80_0000);
    apply(16'hFC00); check("R3 R6 -inf", out_single, 32'hFF80_0000);
  endtask

  task automatic t_nans;
    apply(16'h7C01); check("R4 signalling nan", out_single, 32'h7FC0_2000);
    apply(16'hFE00); check("R4 quiet nan", out_single, 32'hFFC0_0000);
    apply(16'h7DFF); check("R4 payload", out_single, 32'h7FFF_E000);
  endtask

  task automatic t_subnormals;
    apply(16'h0001); check("R5 smallest", out_single, 32'h3380_0000);
    apply(16'h03FF); check("R5 largest", out_single, 32'h387F_C000);
    apply(16'h0200); check("R5 top bit", out_single, 32'h3800_0000);
    apply(16'h8003); check("R5 R6 negative", out_single, 32'hB440_0000);
  endtask

  task automatic t_hold;
    apply(16'h4000);
    in_valid = 1'b0;
    in_half  = 16'h7C00;
    @(negedge clk);
    check("R7 valid drops", {31'd0, out_valid}, 32'd0);
    check("R8 hold", out_single, 32'h4000_0000);
    in_half = 16'h0001;
    @(negedge clk);
    check("R8 hold second idle", out_single, 32'h4000_0000);
  endtask

  task automatic t_sweep;
    logic [31:0] exp;
    for (int i = 0; i < 65536; i++) begin
      apply(16'(i));
      exp = model(16'(i));
      if (exp[30:23] == 8'hFF && exp[22:0] != 23'd0) begin
        vectors++;
        if (out_single[30:23] != 8'hFF || out_single[22:0] == 23'd0 ||
            !out_single[22] || out_single[31] != exp[31]) begin
          miscompares++;
          $display("FAIL R4 sweep %h: got %h expected quiet nan like %h", 16'(i), out_single, exp);
        end
      end else begin
        check("R1 R2 R3 R5 R6 sweep", out_single, exp);
      end
    end
  endtask

  task automatic t_reset_mid;
    apply(16'h3C00);
    rst = 1'b1;
    @(negedge clk);
    check("R9 reset clears valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset clears data", out_single, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_normals();
    t_zeros_infs();
    t_nans();
    t_subnormals();
    t_hold();
    t_sweep();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule